// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block manages a bank of up to 32 pins. Each pin is owned either by an on-chip peripheral signal or by the controller itself. When the controller owns a pin, software chooses the pin's direction and output level. When the peripheral owns it, the peripheral's own output and output-enable pass straight to the pad. Software sets every per-pin attribute (ownership, direction, output data, glitch filter) by writing ones to a set address or a clear address. Each attribute also has a status address that reads back the stored value.

Every pad input passes through a two-flop synchronizer. It can also pass through an optional glitch filter. The result is the pin level, which software can always read. While the peripheral owns a pin, the pin level is also routed to the peripheral. While the controller owns it, the peripheral sees 0. A single interrupt line is raised when any pin level changes. The interrupt is cleared when software reads the level status.

The register bus is a plain synchronous port with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. The data for a read appears on `bus_rdata` in the cycle after `bus_rd`, and it holds until the next read.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: Ownership uses three word addresses on `bus_addr`: 0 gives every pin whose bit is written as 1 to the controller, 1 returns every such pin to the peripheral, and 2 reads the ownership vector (1 = controller). Bits written as 0 leave that pin unchanged.
- R2: `per_in` is 0 for every controller-owned pin. For a peripheral-owned pin, `per_in` carries that pin's level.
- R3: For a controller-owned pin, `pad_oe` and `pad_out` come from the stored direction and data bits. For a peripheral-owned pin, they follow `per_oe` and `per_out`.
- R4: Direction uses address 3 to set (1 = output), address 4 to clear and address 5 to read status. Only the bits written as 1 change.
- R5: Output data uses address 6 to set, address 7 to clear and address 8 to read status. Only the bits written as 1 change.
- R6: Address 12 reads the level of every pin, whatever its ownership and direction. With the filter off, a pad change reaches the level on the third rising edge after the change.
- R7: The glitch filter uses address 9 to enable, address 10 to disable and address 11 to read status. With the filter on, a new level is taken on the fourth rising edge after the pad change, and a pulse lasting one clock is suppressed. The filter works in either ownership mode.
- R8: After reset, every pin is owned by the controller, and direction, data, filter and `irq` are all 0.
- R9: Read data appears in the cycle after `bus_rd`. The set, clear and unused addresses (0, 1, 3, 4, 6, 7, 9, 10, 13 to 15) read as 0.
- R10: `irq` rises on the edge after any pin level changes. A read of address 12 clears it, unless a level changes in the same cycle, in which case `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| per_out | input | NPINS | Peripheral output levels |
| per_oe | input | NPINS | Peripheral output enables |
| per_in | output | NPINS | Pin levels routed to the peripheral |
| irq | output | 1 | Level-change interrupt |

## Verification
Some behaviours are checked by assertions on every cycle:
- the set and clear writes change exactly the bits written as 1;
- the set and clear addresses read as 0;
- `irq` is raised after a level change and dropped after a level read;
- a filtered pin only takes a level that the pad held for two consecutive samples.

Other behaviours only the directed scenarios can show: the ownership mux on the pad and peripheral sides, the exact latency of the unfiltered and filtered paths, the suppression of a one-clock glitch, and the reset values.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RS_OWN_SET  = 4'd0,
    RS_OWN_CLR  = 4'd1,
    RS_OWN_STAT = 4'd2,
    RS_DIR_SET  = 4'd3,
    RS_DIR_CLR  = 4'd4,
    RS_DIR_STAT = 4'd5,
    RS_DAT_SET  = 4'd6,
    RS_DAT_CLR  = 4'd7,
    RS_DAT_STAT = 4'd8,
    RS_FLT_SET  = 4'd9,
    RS_FLT_CLR  = 4'd10,
    RS_FLT_STAT = 4'd11,
    RS_LVL_STAT = 4'd12
  } reg_sel_e;
endpackage

// File: rtl/gpm_sync_filter.sv
module gpm_sync_filter #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] flt_en,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] chg
);
  logic [NPINS-1:0] s1, s2, s3;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic nxt;
    // filtered: accept only when two consecutive samples agree
    always_comb begin
      if (!flt_en[i])        nxt = s2[i];
      else if (s2[i] == s3[i]) nxt = s2[i];
      else                   nxt = lvl[i];
    end
    assign chg[i] = nxt ^ lvl[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i]  <= 1'b0;
        s2[i]  <= 1'b0;
        s3[i]  <= 1'b0;
        lvl[i] <= 1'b0;
      end else begin
        s1[i]  <= pad_in[i];
        s2[i]  <= s1[i];
        s3[i]  <= s2[i];
        lvl[i] <= nxt;
      end
    end
  end
endmodule

// File: rtl/gpm_padmux.sv
module gpm_padmux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dat,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  input  logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] per_in
);
  for (genvar i = 0; i < NPINS; i++) begin : g_mux
    assign pad_out[i] = own[i] ? dat[i] : per_out[i];
    assign pad_oe[i]  = own[i] ? dir[i] : per_oe[i];
    assign per_in[i]  = own[i] ? 1'b0   : lvl[i];
  end
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
  import gpm_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd,
  output logic [BUS_W-1:0]  rdata,
  input  logic [NPINS-1:0]  lvl,
  input  logic [NPINS-1:0]  chg,
  output logic [NPINS-1:0]  own_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dat_q,
  output logic [NPINS-1:0]  flt_q,
  output logic              irq_q
);
  localparam int NATTR = 4;

  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] attr_q [NATTR];
  logic [BUS_W-1:0] rmux;
  logic             rd_lvl;

  assign wbits  = wdata[NPINS-1:0];
  assign rd_lvl = rd && (addr == RS_LVL_STAT);

  // attribute k uses set address 3k, clear 3k+1, status 3k+2
  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(3 * k);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3 * k + 1);
    localparam logic [NPINS-1:0]  RSTV  = (k == 0) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        attr_q[k] <= RSTV;
      else if (wr && addr == A_SET)      attr_q[k] <= attr_q[k] | wbits;
      else if (wr && addr == A_CLR)      attr_q[k] <= attr_q[k] & ~wbits;
    end
  end

  assign own_q = attr_q[0];
  assign dir_q = attr_q[1];
  assign dat_q = attr_q[2];
  assign flt_q = attr_q[3];

  always_comb begin
    rmux = '0;
    case (addr)
      RS_OWN_STAT: rmux[NPINS-1:0] = own_q;
      RS_DIR_STAT: rmux[NPINS-1:0] = dir_q;
      RS_DAT_STAT: rmux[NPINS-1:0] = dat_q;
      RS_FLT_STAT: rmux[NPINS-1:0] = flt_q;
      RS_LVL_STAT: rmux[NPINS-1:0] = lvl;
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  // set wins over a coinciding clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (|chg)    irq_q <= 1'b1;
    else if (rd_lvl)  irq_q <= 1'b0;
  end

  p_own_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RS_OWN_SET) |=> ((own_q & $past(wbits)) == $past(wbits)));
  p_own_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RS_OWN_CLR) |=> ((own_q & $past(wbits)) == '0));
  p_own_zero_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == RS_OWN_SET || addr == RS_OWN_CLR)) |=>
      ((own_q & ~$past(wbits)) == ($past(own_q) & ~$past(wbits))));
  p_dir_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RS_DIR_SET) |=> ((dir_q & $past(wbits)) == $past(wbits)));
  p_dat_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RS_DAT_CLR) |=> ((dat_q & $past(wbits)) == '0));
  p_setclr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == RS_OWN_SET || addr == RS_DIR_CLR || addr == RS_FLT_SET))
      |=> (rdata == '0));
  p_irq_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> irq_q);
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lvl && !(|chg)) |=> !irq_q);
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpm_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  per_out,
  input  logic [NPINS-1:0]  per_oe,
  output logic [NPINS-1:0]  per_in,
  output logic              irq
);
  logic [NPINS-1:0] own_q, dir_q, dat_q, flt_q, lvl, chg;

  gpm_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .lvl(lvl), .chg(chg),
    .own_q(own_q), .dir_q(dir_q), .dat_q(dat_q), .flt_q(flt_q), .irq_q(irq)
  );

  gpm_sync_filter #(.NPINS(NPINS)) filt_i (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .flt_en(flt_q),
    .lvl(lvl), .chg(chg)
  );

  gpm_padmux #(.NPINS(NPINS)) mux_i (
    .own(own_q), .dir(dir_q), .dat(dat_q), .per_out(per_out), .per_oe(per_oe),
    .lvl(lvl), .pad_out(pad_out), .pad_oe(pad_oe), .per_in(per_in)
  );

  // cycles since reset, so the filter check never looks before reset
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  // a filtered pin only takes a level the pad held on two adjacent samples
  p_filter_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd5) |->
      ((($past(flt_q) & (lvl ^ $past(lvl))) &
        (($past(pad_in, 3) ^ $past(pad_in, 4)) | (lvl ^ $past(pad_in, 3)))) == '0));
endmodule

// File: tb/gpio_mux_ctrl_tb_top.sv
module gpio_mux_ctrl_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, per_in;
  logic [N-1:0]  per_out = '0;
  logic [N-1:0]  per_oe = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R8 pad_oe", pad_oe, '0);
    chk("R8 irq", {31'd0, irq}, '0);
    rd(4'd2, d);  chk("R8 own", d, 32'hFFFF_FFFF);
    rd(4'd5, d);  chk("R8 dir", d, '0);
    rd(4'd8, d);  chk("R8 dat", d, '0);
    rd(4'd11, d); chk("R8 flt", d, '0);
  endtask

  task automatic t_own;
    logic [31:0] d;
    wr(4'd1, 32'h0000_00F0);
    rd(4'd2, d); chk("R1 clear", d, 32'hFFFF_FF0F);
    wr(4'd1, 32'h0);
    rd(4'd2, d); chk("R1 zero write", d, 32'hFFFF_FF0F);
    wr(4'd0, 32'h0000_0030);
    rd(4'd2, d); chk("R1 set", d, 32'hFFFF_FF3F);
  endtask

  task automatic t_mux;
    logic [31:0] d;
    per_out = '1; per_oe = '1;
    wr(4'd3, 32'h0000_00FF);
    wr(4'd6, 32'h0000_000F);
    rd(4'd5, d); chk("R4 dir stat", d, 32'h0000_00FF);
    rd(4'd8, d); chk("R5 dat stat", d, 32'h0000_000F);
    chk("R3 oe", pad_oe, 32'h0000_00FF);
    chk("R3 out", pad_out, 32'h0000_00CF);
    wr(4'd4, 32'h0000_0001);
    wr(4'd7, 32'h0000_0003);
    per_oe = '0;
    rd(4'd5, d); chk("R4 dir clr", d, 32'h0000_00FE);
    rd(4'd8, d); chk("R5 dat clr", d, 32'h0000_000C);
    @(negedge clk);
    chk("R3 oe per", pad_oe, 32'h0000_003E);
    chk("R3 out per", pad_out, 32'h0000_00CC);
  endtask

  task automatic t_level;
    logic [31:0] d;
    pad_in = '1;
    repeat (5) @(negedge clk);
    chk("R2 per_in", per_in, 32'h0000_00C0);
    chk("R10 irq set", {31'd0, irq}, 32'd1);
    rd(4'd12, d); chk("R6 level", d, 32'hFFFF_FFFF);
    chk("R10 irq clear", {31'd0, irq}, 32'd0);
    // unfiltered latency on peripheral pin 6
    pad_in[6] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet", {31'd0, per_in[6]}, 32'd1);
    @(negedge clk);
    chk("R6 third edge", {31'd0, per_in[6]}, 32'd0);
    rd(4'd12, d); chk("R6 level pin6", d, 32'hFFFF_FFBF);
  endtask

  task automatic t_filter;
    logic [31:0] d;
    wr(4'd9, 32'h0000_0080);
    rd(4'd11, d); chk("R7 flt stat", d, 32'h0000_0080);
    rd(4'd12, d);
    chk("R10 irq idle", {31'd0, irq}, 32'd0);
    pad_in[7] = 1'b0;
    @(negedge clk); pad_in[7] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 glitch held", {31'd0, per_in[7]}, 32'd1);
    end
    chk("R10 no irq on glitch", {31'd0, irq}, 32'd0);
    pad_in[7] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 not yet", {31'd0, per_in[7]}, 32'd1);
    @(negedge clk);
    chk("R7 fourth edge", {31'd0, per_in[7]}, 32'd0);
    rd(4'd10, d); chk("R9 clr reads 0", d, '0);
    rd(4'd0, d);  chk("R9 set reads 0", d, '0);
    rd(4'd15, d); chk("R9 unused reads 0", d, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_own();
    t_mux();
    t_level();
    t_filter();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule